// File: doc/BRIEF.md
# Asynchronous ROM read controller

This block sits on the host side of an asynchronous, byte-wide, read-only memory. It runs on the system clock. The memory has a separate active-low chip-enable (E) and active-low output-enable (G). The host raises `req_valid` with an address. The controller latches the address, drives it onto the memory address pins and pulls E low in the same cycle. G follows one cycle later. The controller then waits until every access-time limit of the part is met, samples the data bus on a single clock edge and returns the byte with a one-cycle `rsp_valid` strobe.

The part has three timing limits: address-to-data, E-to-data and G-to-data. Each is a parameter in nanoseconds. It is rounded up to whole clock cycles with the clock period parameter. The sample edge is the latest of the three, measured from the cycle in which address and E were presented. The G limit counts from one cycle later, because G is asserted one cycle after E. The sample edge is never earlier than three cycles. After sampling, E and G are released together. The memory's outputs may take some time to float, so the controller stays busy for a float gap of `FLOAT_NS` rounded up to cycles before it accepts another request. This way the next driver of the data bus never collides with the memory.

The sequencer has six states:
- IDLE: waits for a request. The transition IDLE→SETUP is taken on `req_valid`.
- SETUP: address and E are driven. SETUP→ENABLE_OUT is unconditional.
- ENABLE_OUT: G is asserted. ENABLE_OUT→WAIT is taken while the sample edge is still ahead. ENABLE_OUT→SAMPLE is taken when the sample edge is the next one.
- WAIT: holds for the remaining access time. WAIT→SAMPLE is taken when the cycle counter reaches the sample point.
- SAMPLE: the data is captured at the end of this cycle. SAMPLE→FLOAT is unconditional.
- FLOAT: E and G are high and the address is still held. FLOAT→IDLE is taken after the float cycles.

Top module: `async_rom_reader`

## Requirements
- R1: While `rst_n` is low, and from the first cycle after it falls, `mem_ce_n` and `mem_oe_n` are 1, `busy` is 0 and `rsp_valid` is 0. A reset in the middle of a read abandons that read.
- R2: Let S be the largest of ceil(ADDR_ACC_NS/CLK_NS), ceil(CE_ACC_NS/CLK_NS), ceil(OE_ACC_NS/CLK_NS)+1 and 3. `rsp_data` equals the value on `mem_dq` at the clock edge S cycles after the edge that accepted the request. The default is S = 12.
- R3: If a request is accepted at edge A, `rsp_valid` is 1 during the cycle that follows edge A+S. With the defaults, that is the 13th cycle after acceptance.
- R4: `mem_ce_n` falls on the accepting edge, and `mem_oe_n` falls exactly one edge later. `mem_oe_n` is never 0 while `mem_ce_n` is 1. Both return to 1 on edge A+S.
- R5: `mem_addr` takes the requested address on the accepting edge. It does not change until the controller returns to idle.
- R6: A request is accepted on an edge where `req_valid` is 1 and the controller is idle. `busy` is 1 from the accepting edge until edge A+S+F, where F = max(1, ceil(FLOAT_NS/CLK_NS)). The default is F = 5. `busy` is 0 again after that edge.
- R7: A `req_valid` raised while `busy` is 1 has no effect. It changes neither `mem_addr` nor the returned data, and it produces no extra `rsp_valid`.
- R8: Between the release of E at the end of one read and its fall for the next read, `mem_ce_n` stays 1 for at least F cycles, including when requests are back to back.
- R9: Each accepted read produces exactly one `rsp_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request; taken when the controller is idle |
| req_addr | input | AW | Byte address of the request |
| busy | output | 1 | A read or its float gap is in progress |
| rsp_valid | output | 1 | One-cycle strobe marking `rsp_data` valid |
| rsp_data | output | DW | Byte read from the memory |
| mem_addr | output | AW | Memory address pins |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq | input | DW | Memory data bus |

## Verification
The hardest case to create from the ports is a request that arrives just as the float gap ends. The controller then accepts it on the first idle edge, which leaves the minimum E-high interval between two reads. The bench holds `req_valid` high across a whole read and changes the address while the first read is still busy. This makes the second read start on the earliest legal edge, so the float gap and the ignoring of busy-time requests are both observed at their tightest. The memory model drives the complement of the stored byte until all three access limits have elapsed in whole cycles. Any early sample therefore returns a visibly wrong byte.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ENABLE_OUT,
        ST_WAIT,
        ST_SAMPLE,
        ST_FLOAT
    } rd_state_e;

    // Round a delay in nanoseconds up to whole clock cycles.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rdc_timer.sv
module rdc_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rdc_seq.sv
module rdc_seq
    import rdc_pkg::*;
#(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned SAMPLE_AT = 12,
    parameter int unsigned FLOAT_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] cnt,
    output logic             accept,
    output logic             tmr_clr,
    output logic             capture,
    output logic             ce_n,
    output logic             oe_n,
    output logic             busy
);

    localparam logic [CNT_W-1:0] LAST_WAIT  = CNT_W'(SAMPLE_AT - 2);
    localparam logic [CNT_W-1:0] LAST_FLOAT = CNT_W'(FLOAT_CYC - 1);

    rd_state_e state_q, state_d;
    logic      ce_n_q, oe_n_q, busy_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = ST_SETUP;
            ST_SETUP:      state_d = ST_ENABLE_OUT;
            ST_ENABLE_OUT: state_d = (cnt == LAST_WAIT) ? ST_SAMPLE : ST_WAIT;
            ST_WAIT:       if (cnt == LAST_WAIT) state_d = ST_SAMPLE;
            ST_SAMPLE:     state_d = ST_FLOAT;
            ST_FLOAT:      if (cnt == LAST_FLOAT) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered pin strobes decoded from the next state, so they switch
    // on the same edge as the state and never glitch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
            oe_n_q <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            ce_n_q <= !(state_d inside {ST_SETUP, ST_ENABLE_OUT, ST_WAIT, ST_SAMPLE});
            oe_n_q <= !(state_d inside {ST_ENABLE_OUT, ST_WAIT, ST_SAMPLE});
            busy_q <= (state_d != ST_IDLE);
        end
    end

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign tmr_clr = (state_q == ST_IDLE) || (state_q == ST_SAMPLE);
    assign capture = (state_q == ST_SAMPLE);
    assign ce_n    = ce_n_q;
    assign oe_n    = oe_n_q;
    assign busy    = busy_q;

endmodule

// File: rtl/rdc_datapath.sv
module rdc_datapath #(
    parameter int unsigned AW = 19,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] mem_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= capture;
            if (capture) begin
                data_q <= dq_in;
            end
        end
    end

    assign mem_addr  = addr_q;
    assign rsp_valid = vld_q;
    assign rsp_data  = data_q;

endmodule

// File: rtl/async_rom_reader.sv
module async_rom_reader
    import rdc_pkg::*;
#(
    parameter int unsigned AW          = 19,
    parameter int unsigned DW          = 8,
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned ADDR_ACC_NS = 120,
    parameter int unsigned CE_ACC_NS   = 120,
    parameter int unsigned OE_ACC_NS   = 60,
    parameter int unsigned FLOAT_NS    = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    input  logic [DW-1:0] mem_dq
);

    localparam int unsigned ADDR_CYC  = ns_to_cyc(ADDR_ACC_NS, CLK_NS);
    localparam int unsigned CE_CYC    = ns_to_cyc(CE_ACC_NS, CLK_NS);
    // G falls one cycle after E, so its limit counts from cycle 1.
    localparam int unsigned OE_CYC    = ns_to_cyc(OE_ACC_NS, CLK_NS) + 1;
    localparam int unsigned SAMPLE_AT = max2(max2(ADDR_CYC, CE_CYC), max2(OE_CYC, 3));
    localparam int unsigned FLOAT_CYC = max2(ns_to_cyc(FLOAT_NS, CLK_NS), 1);
    localparam int unsigned CNT_W     = $clog2(max2(SAMPLE_AT, FLOAT_CYC) + 1);

    logic             accept, tmr_clr, capture;
    logic [CNT_W-1:0] cnt;

    rdc_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (cnt)
    );

    rdc_seq #(
        .CNT_W     (CNT_W),
        .SAMPLE_AT (SAMPLE_AT),
        .FLOAT_CYC (FLOAT_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cnt       (cnt),
        .accept    (accept),
        .tmr_clr   (tmr_clr),
        .capture   (capture),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .busy      (busy)
    );

    rdc_datapath #(
        .AW (AW),
        .DW (DW)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .capture   (capture),
        .dq_in     (mem_dq),
        .mem_addr  (mem_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
    parameter int unsigned AW        = 19,
    parameter int unsigned SAMPLE_AT = 12,
    parameter int unsigned FLOAT_CYC = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n
);

    int unsigned low_run;
    int unsigned high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run  <= 0;
            high_run <= FLOAT_CYC;
        end else begin
            if (!mem_ce_n) begin
                if (low_run < 1000) low_run <= low_run + 1;
                high_run <= 0;
            end else begin
                low_run <= 0;
                if (high_run < 1000) high_run <= high_run + 1;
            end
        end
    end

    AST_OE_WITHIN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);                                   // R4

    AST_OE_LAGS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$fell(mem_ce_n));                      // R4

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));             // R5

    AST_BUSY_COVERS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> busy);                                        // R6

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                  // R9

    AST_ACCESS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (low_run >= SAMPLE_AT));                      // R2

    AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (high_run >= FLOAT_CYC));               // R8

endmodule

bind async_rom_reader rdc_checker #(
    .AW        (AW),
    .SAMPLE_AT (SAMPLE_AT),
    .FLOAT_CYC (FLOAT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/async_rom_reader_test.sv
`timescale 1ns/1ps
module async_rom_reader_test;

    localparam int AW     = 19;
    localparam int DW     = 8;
    localparam int CLK_NS = 10;
    localparam int A_NS   = 120;
    localparam int E_NS   = 120;
    localparam int G_NS   = 60;
    localparam int F_NS   = 50;

    // Expected timing from the requirements (R2, R3, R6).
    localparam int S_A    = (A_NS + CLK_NS - 1) / CLK_NS;
    localparam int S_E    = (E_NS + CLK_NS - 1) / CLK_NS;
    localparam int S_G    = (G_NS + CLK_NS - 1) / CLK_NS + 1;
    localparam int S01    = (S_A > S_E) ? S_A : S_E;
    localparam int S23    = (S_G > 3) ? S_G : 3;
    localparam int S_CYC  = (S01 > S23) ? S01 : S23;
    localparam int F_RAW  = (F_NS + CLK_NS - 1) / CLK_NS;
    localparam int F_CYC  = (F_RAW > 1) ? F_RAW : 1;
    localparam int RSP_N  = S_CYC + 1;
    localparam int IDLE_N = S_CYC + F_CYC + 1;

    // Vector table: {idle cycles before request, address}.
    localparam logic [22:0] VECS [6] = '{
        {4'd0, 19'h00000},
        {4'd3, 19'h7FFFF},
        {4'd1, 19'h12345},
        {4'd0, 19'h5A5A5},
        {4'd7, 19'h00001},
        {4'd2, 19'h40000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          busy, rsp_valid, mem_ce_n, mem_oe_n;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    async_rom_reader uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq    (mem_dq)
    );

    function automatic logic [DW-1:0] rom_byte(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model, updated away from the active edge. It drives the stored
    // byte only when all three limits are met by the next rising edge.
    int            ce_ticks = 0, oe_ticks = 0, a_ticks = 100, ce_hi = 0;
    bit            had_low  = 0;
    logic [AW-1:0] prev_addr = '0;

    always @(negedge clk) begin
        if (mem_addr != prev_addr) begin
            a_ticks   = 1;
            prev_addr = mem_addr;
        end else if (a_ticks < 100) begin
            a_ticks++;
        end
        if (!mem_ce_n) begin
            ce_ticks++;
            if (ce_ticks == 1 && had_low)
                chk(ce_hi >= F_CYC, "R8", "E high gap", ce_hi, F_CYC);
            had_low = 1;
            ce_hi   = 0;
        end else begin
            ce_ticks = 0;
            ce_hi++;
        end
        if (!mem_oe_n) begin
            oe_ticks++;
            if (oe_ticks == 1)
                chk(ce_ticks == 2, "R4", "E ticks when G falls", ce_ticks, 2);
        end else begin
            oe_ticks = 0;
        end
        if (ce_ticks * CLK_NS >= E_NS && oe_ticks * CLK_NS >= G_NS &&
            a_ticks * CLK_NS >= A_NS)
            mem_dq = rom_byte(mem_addr);
        else
            mem_dq = ~rom_byte(mem_addr);
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic do_read(input logic [AW-1:0] a);
        int  n;
        int  pulses;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        pulses = 0;
        while (busy && n < 200) begin
            chk(mem_addr == a, "R5", "address held", int'(mem_addr), int'(a));
            if (rsp_valid) begin
                pulses++;
                chk(n == RSP_N, "R3", "response cycle", n, RSP_N);
                chk(rsp_data == rom_byte(a), "R2", "read data",
                    int'(rsp_data), int'(rom_byte(a)));
            end
            @(negedge clk);
            n++;
        end
        chk(pulses == 1, "R9", "response pulses", pulses, 1);
        chk(n == IDLE_N, "R6", "busy release cycle", n, IDLE_N);
    endtask

    initial begin
        int n;
        int pulses;
        logic [7:0] got;

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(mem_ce_n == 1'b1, "R1", "ce_n in reset", int'(mem_ce_n), 1);
        chk(mem_oe_n == 1'b1, "R1", "oe_n in reset", int'(mem_oe_n), 1);
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table of reads: R2, R3, R5, R6, R9.
        foreach (VECS[i]) begin
            repeat (int'(VECS[i][22:19])) @(negedge clk);
            do_read(VECS[i][18:0]);
        end

        // R7: request raised while busy is ignored.
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 19'h0ABCD;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        pulses = 0;
        while (busy && n < 200) begin
            if (n == 3) begin
                req_valid = 1'b1;
                req_addr  = 19'h71717;
            end
            if (n == RSP_N + 2) req_valid = 1'b0;
            chk(mem_addr == 19'h0ABCD, "R7", "address under busy request",
                int'(mem_addr), 'h0ABCD);
            if (rsp_valid) begin
                pulses++;
                chk(rsp_data == rom_byte(19'h0ABCD), "R7", "data under busy request",
                    int'(rsp_data), int'(rom_byte(19'h0ABCD)));
            end
            @(negedge clk);
            n++;
        end
        chk(pulses == 1, "R7", "responses under busy request", pulses, 1);
        repeat (3) begin
            chk(busy == 1'b0 && mem_ce_n == 1'b1, "R7", "no late accept",
                int'(busy), 0);
            @(negedge clk);
        end

        // R8: back-to-back requests, second one pending during the float gap.
        req_valid = 1'b1;
        req_addr  = 19'h33333;
        @(negedge clk);
        n = 0;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        got = rsp_data;
        chk(got == rom_byte(19'h33333), "R2", "first back-to-back data",
            int'(got), int'(rom_byte(19'h33333)));
        req_addr = 19'h4C4C4;
        while (busy && n < 400) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8", "second read accepted at first idle edge",
            int'(busy), 1);
        n = 0;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(rsp_data == rom_byte(19'h4C4C4), "R2", "second back-to-back data",
            int'(rsp_data), int'(rom_byte(19'h4C4C4)));
        while (busy) @(negedge clk);

        // R1: reset in the middle of a read.
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 19'h22222;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_ce_n == 1'b1, "R1", "ce_n after mid-read reset", int'(mem_ce_n), 1);
        chk(mem_oe_n == 1'b1, "R1", "oe_n after mid-read reset", int'(mem_oe_n), 1);
        chk(busy == 1'b0, "R1", "busy after mid-read reset", int'(busy), 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after mid-read reset",
            int'(rsp_valid), 0);
        rst_n = 1'b1;
        repeat (F_CYC + 1) @(negedge clk);
        do_read(19'h6F0F0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule